// File: doc/BRIEF.md
# ADC Offset and Gain Self-Calibration Sequencer

This block sits behind the decimation filter of an oversampling converter. In normal running it takes each filter result, removes a stored offset, scales the difference by a stored gain factor, and publishes the corrected word together with a one-cycle data-ready strobe. The filter produces one result every 64 clocks and marks it with a strobe.

On a calibration request the block takes over the selector that feeds the modulator input. It lets the conversion in progress finish, then steps through a fixed schedule of measurement phases. Each phase applies a known input, waits for the filter to settle, and averages eight filter results. Unipolar mode uses two phases (ground, then plus full scale). Bipolar mode uses three phases (ground, plus full scale, minus full scale). A sequential divider then turns the measured span into a gain factor. Offset and gain are loaded together, the selector returns to the external pins, and the output is flagged invalid for one more settling period.

A rising edge on either the sync or the restart input abandons a calibration at once. The stored coefficients are then left as they were.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset, in_sel is 0 (external pins), valid is 1, ready_n is 1, data_out is 0, the offset is zero and the gain is unity (16384 in Q2.14), so each corrected word equals its filter input.
- R2: When filt_stb is sampled high while no calibration is pending or running, data_out takes sat16(((filt_data - offset) * gain) >>> 14) on that edge, and ready_n is low for exactly that one following cycle.
- R3: When cal_req is sampled high while idle, calibration begins at the next filter strobe, no more than 64 clocks later. From then until the calibration ends, in_sel leaves 0, valid is low (except for R7 pulses) and ready_n is held high.
- R4: The selector codes are 1 = shorted to ground, 2 = plus full scale and 3 = minus full scale. Each measurement phase holds its code for SETTLE + 8x64 = 8704 clocks: settling, then the average of the next eight strobed results.
- R5: In unipolar mode the phases are ground then plus full scale. The offset becomes the ground average. The gain becomes floor(32767 * 2^14 / (plus average - ground average)).
- R6: In bipolar mode the phases are ground, plus full scale, then minus full scale. The offset becomes the ground average. The gain becomes floor(65534 * 2^14 / (plus average - minus average)).
- R7: valid is high for a single cycle at the end of each phase's averaging, so a calibration shows one pulse per phase.
- R8: Once the coefficients are loaded, in_sel returns to 0. valid stays low for a further SETTLE (8192) clocks and then rises, and normal correction resumes.
- R9: The unipolar/bipolar choice is latched when cal_req is accepted; a later change of bipolar_in does not alter the running schedule.
- R10: A rising edge on sync_in or restart_in while a calibration is pending or running returns in_sel to 0 and valid to 1 on the next cycle, and leaves offset and gain unchanged.
- R11: The corrected output saturates to [-32768, 32767]. The gain saturates at 65535 when the quotient exceeds 16 bits or the measured span is not positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on clear) |
| cal_req | input | 1 | Calibration request, level sampled while idle |
| sync_in | input | 1 | Abort on rising edge during calibration |
| restart_in | input | 1 | Abort on rising edge during calibration |
| bipolar_in | input | 1 | 1 = bipolar input range, 0 = unipolar |
| filt_stb | input | 1 | Filter result strobe, one cycle every 64 clocks |
| filt_data | input | 16 | Signed filter result |
| data_out | output | 16 | Signed corrected result |
| in_sel | output | 2 | Modulator input selection: 0 pins, 1 ground, 2 plus FS, 3 minus FS |
| valid | output | 1 | High when output data is valid; single-cycle pulses during calibration |
| ready_n | output | 1 | Low for one cycle when a new corrected word is presented |

## Verification
The correction path is driven first with unity coefficients and then with the coefficients from each kind of calibration. Mid-range, full-scale positive and full-scale negative inputs are used: the first separates a missing subtraction from a wrong gain, and the extremes show whether saturation happens after scaling. A bench model returns a distinct constant for each selector code. Every learned coefficient therefore traces back to a specific phase, and exact phase lengths and pulse counts tell the unipolar schedule from the bipolar one. Aborts in the first and in the second phase, with changed model values, show whether partially measured results leak into the stored coefficients. A narrow measured span forces the gain clamp.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_GND  = 2'd1,
    SEL_POS  = 2'd2,
    SEL_NEG  = 2'd3
  } insel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETTLE,
    ST_ACCUM,
    ST_DIV,
    ST_POST
  } cal_st_e;
endpackage

// File: rtl/cal_avg.sv
module cal_avg #(
  parameter int DW    = 16,
  parameter int NSAMP = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 take,
  input  logic [DW-1:0]        din,
  output logic                 last,
  output logic [DW-1:0]        avg
);
  localparam int CW = $clog2(NSAMP);
  localparam int SW = DW + CW;

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] nxt;
  logic [CW-1:0]        cnt;

  assign nxt  = sum + $signed({{CW{din[DW-1]}}, din});
  assign last = take && (cnt == CW'(NSAMP - 1));
  assign avg  = nxt[CW +: DW];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum <= '0;
      cnt <= '0;
    end else if (take) begin
      if (last) begin
        sum <= '0;
        cnt <= '0;
      end else begin
        sum <= nxt;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: a finished window always restarts from an empty accumulator
  a_r4_window_restart: assert property (@(posedge clk) disable iff (rst)
    (last && !clr) |=> (cnt == '0));
endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int NW  = 32,
  parameter int DNW = 17
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NW-1:0]  num,
  input  logic [DNW-1:0] den,
  output logic           done,
  output logic [NW-1:0]  quot
);
  localparam int IW = $clog2(NW + 1);

  logic [DNW-1:0] rem;
  logic [DNW-1:0] dv;
  logic [NW-1:0]  q;
  logic [IW-1:0]  it;
  logic           busy;
  logic [DNW:0]   shifted;
  logic [DNW+1:0] trial;
  logic           ge;

  assign shifted = {rem, q[NW-1]};
  assign trial   = {1'b0, shifted} - {2'b00, dv};
  assign ge      = ~trial[DNW+1];
  assign quot    = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      dv   <= '0;
      q    <= '0;
      it   <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        dv   <= den;
        q    <= num;
        it   <= IW'(NW);
        busy <= 1'b1;
      end else if (busy) begin
        q   <= {q[NW-2:0], ge};
        rem <= ge ? trial[DNW-1:0] : shifted[DNW-1:0];
        it  <= it - 1'b1;
        if (it == IW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5: completion is a single-cycle event
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
  parameter int DW   = 16,
  parameter int GW   = 16,
  parameter int FRAC = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] offset,
  input  logic [GW-1:0] gain,
  output logic [DW-1:0] dout
);
  localparam int PW = DW + GW + 2;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW:0]   diff;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic [DW-1:0]        sat;

  assign diff   = $signed({din[DW-1], din}) - $signed({offset[DW-1], offset});
  assign prod   = diff * $signed({1'b0, gain});
  assign scaled = prod >>> FRAC;

  always_comb begin
    if (scaled > MAXV)      sat = MAXV[DW-1:0];
    else if (scaled < MINV) sat = MINV[DW-1:0];
    else                    sat = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= sat;
  end

  // R2: the output word only moves on a load
  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dout));
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
  import adc_cal_pkg::*;
#(
  parameter int DW     = 16,
  parameter int SETTLE = 8192,
  parameter int NAVG   = 8,
  parameter int GW     = 16,
  parameter int FRAC   = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cal_req,
  input  logic          sync_in,
  input  logic          restart_in,
  input  logic          bipolar_in,
  input  logic          filt_stb,
  input  logic [DW-1:0] filt_data,
  output logic [DW-1:0] data_out,
  output logic [1:0]    in_sel,
  output logic          valid,
  output logic          ready_n
);
  localparam int CNTW      = $clog2(SETTLE);
  localparam int IDEAL_UNI = (2 ** (DW - 1)) - 1;
  localparam int IDEAL_BI  = 2 * IDEAL_UNI;
  localparam int NW        = DW + 2 + FRAC;
  localparam int DNW       = DW + 1;
  localparam logic [NW-1:0] NUM_UNI = NW'(IDEAL_UNI) << FRAC;
  localparam logic [NW-1:0] NUM_BI  = NW'(IDEAL_BI) << FRAC;
  localparam logic [GW-1:0] UNITY   = GW'(1) << FRAC;

  cal_st_e         state;
  insel_e          sel_q;
  logic            mode_q;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   offset_q, stg_zero, stg_pos, stg_lo;
  logic [GW-1:0]   gain_q;
  logic            sync_q, restart_q;
  logic            valid_q, ready_q;
  logic            div_go, span_bad;
  logic            abort;
  logic            avg_last;
  logic [DW-1:0]   avg_val;
  logic            div_done;
  logic [NW-1:0]   div_quot;
  logic signed [DNW-1:0] span;

  assign abort = (state != ST_IDLE) &&
                 ((sync_in && !sync_q) || (restart_in && !restart_q));
  assign span  = $signed({stg_pos[DW-1], stg_pos}) - $signed({stg_lo[DW-1], stg_lo});

  cal_avg #(.DW(DW), .NSAMP(NAVG)) u_avg (
    .clk  (clk),
    .rst  (rst),
    .clr  (state != ST_ACCUM),
    .take (state == ST_ACCUM && filt_stb),
    .din  (filt_data),
    .last (avg_last),
    .avg  (avg_val)
  );

  cal_divider #(.NW(NW), .DNW(DNW)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_go),
    .num   (mode_q ? NUM_BI : NUM_UNI),
    .den   ($unsigned(span)),
    .done  (div_done),
    .quot  (div_quot)
  );

  cal_corrector #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_cor (
    .clk    (clk),
    .rst    (rst),
    .load   (state == ST_IDLE && filt_stb),
    .din    (filt_data),
    .offset (offset_q),
    .gain   (gain_q),
    .dout   (data_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      sync_q    <= sync_in;
      restart_q <= restart_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sel_q    <= SEL_PINS;
      mode_q   <= 1'b0;
      cnt      <= '0;
      offset_q <= '0;
      gain_q   <= UNITY;
      stg_zero <= '0;
      stg_pos  <= '0;
      stg_lo   <= '0;
      valid_q  <= 1'b1;
      ready_q  <= 1'b1;
      div_go   <= 1'b0;
      span_bad <= 1'b0;
    end else begin
      div_go  <= 1'b0;
      ready_q <= 1'b1;
      if (abort) begin
        state   <= ST_IDLE;
        sel_q   <= SEL_PINS;
        valid_q <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            ready_q <= ~filt_stb;
            if (cal_req) begin
              state  <= ST_WAIT;
              mode_q <= bipolar_in;
            end
          end
          ST_WAIT: begin
            if (filt_stb) begin
              state   <= ST_SETTLE;
              sel_q   <= SEL_GND;
              cnt     <= '0;
              valid_q <= 1'b0;
            end
          end
          ST_SETTLE: begin
            valid_q <= 1'b0;
            if (cnt == CNTW'(SETTLE - 1)) begin
              state <= ST_ACCUM;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACCUM: begin
            if (avg_last) begin
              valid_q <= 1'b1;
              case (sel_q)
                SEL_GND: begin
                  stg_zero <= avg_val;
                  stg_lo   <= avg_val;
                  sel_q    <= SEL_POS;
                  state    <= ST_SETTLE;
                end
                SEL_POS: begin
                  stg_pos <= avg_val;
                  if (mode_q) begin
                    sel_q <= SEL_NEG;
                    state <= ST_SETTLE;
                  end else begin
                    state  <= ST_DIV;
                    div_go <= 1'b1;
                  end
                end
                default: begin
                  stg_lo <= avg_val;
                  state  <= ST_DIV;
                  div_go <= 1'b1;
                end
              endcase
            end
          end
          ST_DIV: begin
            valid_q <= 1'b0;
            if (div_go) span_bad <= (span <= 0);
            if (div_done) begin
              gain_q   <= (span_bad || (|div_quot[NW-1:GW])) ? '1 : div_quot[GW-1:0];
              offset_q <= stg_zero;
              sel_q    <= SEL_PINS;
              state    <= ST_POST;
              cnt      <= '0;
            end
          end
          ST_POST: begin
            if (cnt == CNTW'(SETTLE - 1)) begin
              state   <= ST_IDLE;
              valid_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign in_sel  = sel_q;
  assign valid   = valid_q;
  assign ready_n = ready_q;

  // R10: an abort edge returns the selector and validity at once
  a_r10_abort_to_pins: assert property (@(posedge clk) disable iff (rst)
    abort |=> (in_sel == SEL_PINS && valid));

  // R3: no data-ready strobe while measuring
  a_r3_ready_held: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_SETTLE, ST_ACCUM, ST_DIV, ST_POST}) |-> ready_n);

  // R7: phase-end pulses last one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (valid && (state inside {ST_SETTLE, ST_DIV}) && !abort) |=> !valid);

  // R8: post-load settling keeps pins selected and data invalid
  a_r8_post_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST) |-> (!valid && in_sel == SEL_PINS));

  // R4: the selector does not move while settling
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && cnt != '0) |-> $stable(in_sel));

  // R2: an idle strobe produces a data-ready low cycle
  a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && filt_stb && !cal_req) |=> !ready_n);
endmodule

// File: tb/sim_adc_cal_sequencer.sv
module sim_adc_cal_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_req = 1'b0;
  logic        sync_in = 1'b0;
  logic        restart_in = 1'b0;
  logic        bipolar_in = 1'b0;
  logic        filt_stb = 1'b0;
  logic [15:0] filt_data = '0;
  logic [15:0] data_out;
  logic [1:0]  in_sel;
  logic        valid;
  logic        ready_n;

  int errs = 0;
  int checks = 0;
  int gnd_v = 0, pos_v = 0, neg_v = 0, pin_v = 0;
  longint exp_off = 0;
  longint exp_gain = 16384;
  bit started = 1'b0;

  adc_cal_sequencer u0 (
    .clk(clk), .rst(rst), .cal_req(cal_req), .sync_in(sync_in),
    .restart_in(restart_in), .bipolar_in(bipolar_in), .filt_stb(filt_stb),
    .filt_data(filt_data), .data_out(data_out), .in_sel(in_sel),
    .valid(valid), .ready_n(ready_n)
  );

  always #10 clk = ~clk;

  // filter model: one strobe every 64 clocks, value set by the selector
  initial begin
    wait (started);
    forever begin
      repeat (63) @(negedge clk);
      case (in_sel)
        2'd1:    filt_data = 16'(gnd_v);
        2'd2:    filt_data = 16'(pos_v);
        2'd3:    filt_data = 16'(neg_v);
        default: filt_data = 16'(pin_v);
      endcase
      filt_stb = 1'b1;
      @(negedge clk);
      filt_stb = 1'b0;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_out(input longint x);
    longint p;
    p = ((x - exp_off) * exp_gain) >>> 14;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  function automatic longint calc_gain(input longint ideal, input longint span);
    longint q;
    if (span <= 0) return 65535;
    q = (ideal * 16384) / span;
    return (q > 65535) ? 65535 : q;
  endfunction

  task automatic wait_ready();
    do @(negedge clk); while (ready_n !== 1'b0);
  endtask

  task automatic check_normal(input string req, input int x);
    pin_v = x;
    wait_ready();
    wait_ready();
    chk(req, longint'($signed(data_out)), expect_out(x));
    @(negedge clk);
    chk({req, " ready one cycle"}, ready_n, 1);
  endtask

  task automatic run_cal(input bit bip);
    int n, gnd_len, pos_len, neg_len, pulses, rdy_bad;
    n = 0; gnd_len = 0; pos_len = 0; neg_len = 0; pulses = 0; rdy_bad = 0;
    @(negedge clk);
    cal_req = 1'b1;
    bipolar_in = bip;
    @(negedge clk);
    cal_req = 1'b0;
    bipolar_in = ~bip;  // R9: must not affect the running calibration
    while (in_sel == 2'd0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R3 start delay within 64", (n <= 64) ? 1 : 0, 1);
    chk("R3 valid low at start", valid, 0);
    while (in_sel != 2'd0) begin
      if (in_sel == 2'd1) gnd_len++;
      if (in_sel == 2'd2) pos_len++;
      if (in_sel == 2'd3) neg_len++;
      if (valid) pulses++;
      if (!ready_n) rdy_bad++;
      @(negedge clk);
    end
    chk("R3 ready_n held high", rdy_bad, 0);
    chk("R4 ground phase length", gnd_len, 8704);
    if (bip) begin
      chk("R6 plus phase length", pos_len, 8704);
      chk("R9 bipolar runs three phases", (neg_len >= 8704) ? 1 : 0, 1);
      chk("R7 one pulse per phase (bipolar)", pulses, 3);
      exp_off = gnd_v;
      exp_gain = calc_gain(65534, pos_v - neg_v);
    end else begin
      chk("R5 no minus phase in unipolar", neg_len, 0);
      chk("R7 one pulse per phase (unipolar)", pulses, 2);
      exp_off = gnd_v;
      exp_gain = calc_gain(32767, pos_v - gnd_v);
    end
    repeat (8191) @(negedge clk);
    chk("R8 valid low during post settle", valid, 0);
    @(negedge clk);
    chk("R8 valid high after post settle", valid, 1);
  endtask

  task automatic t_reset();
    chk("R1 in_sel at reset", in_sel, 0);
    chk("R1 valid at reset", valid, 1);
    chk("R1 ready_n at reset", ready_n, 1);
    chk("R1 data_out at reset", data_out, 0);
  endtask

  task automatic t_passthrough();
    check_normal("R1 unity passthrough positive", 1234);
    check_normal("R2 unity passthrough negative", -500);
  endtask

  task automatic t_unipolar();
    gnd_v = 100; pos_v = 30000;
    run_cal(1'b0);
    check_normal("R5 unipolar mid-range", 15000);
    check_normal("R11 unipolar saturate high", 32767);
    check_normal("R11 unipolar saturate low", -32768);
  endtask

  task automatic t_bipolar();
    gnd_v = -50; pos_v = 31000; neg_v = -31500;
    run_cal(1'b1);
    check_normal("R6 bipolar zero input", 0);
    check_normal("R6 bipolar negative input", -20000);
  endtask

  task automatic t_abort_sync();
    gnd_v = 999; pos_v = 5000; neg_v = -5000;
    @(negedge clk);
    cal_req = 1'b1;
    @(negedge clk);
    cal_req = 1'b0;
    while (in_sel == 2'd0) @(negedge clk);
    repeat (100) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    chk("R10 sync abort selects pins", in_sel, 0);
    chk("R10 sync abort valid", valid, 1);
    sync_in = 1'b0;
    check_normal("R10 coefficients kept after sync abort", 7000);
  endtask

  task automatic t_abort_restart();
    gnd_v = 2500; pos_v = 9000;
    @(negedge clk);
    cal_req = 1'b1;
    bipolar_in = 1'b0;
    @(negedge clk);
    cal_req = 1'b0;
    while (in_sel != 2'd2) @(negedge clk);
    repeat (50) @(negedge clk);
    restart_in = 1'b1;
    @(negedge clk);
    chk("R10 restart abort selects pins", in_sel, 0);
    restart_in = 1'b0;
    check_normal("R10 offset kept after restart abort", -1000);
  endtask

  task automatic t_gain_sat();
    gnd_v = 0; pos_v = 1000;
    run_cal(1'b0);
    chk("R11 gain clamps to 65535", exp_gain, 65535);
    check_normal("R11 output with clamped gain", 100);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    started = 1'b1;
    t_passthrough();
    t_unipolar();
    t_bipolar();
    t_abort_sync();
    t_abort_restart();
    t_gain_sat();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule